// File: doc/BRIEF.md
# Effective Address Resolver with Pre-Increment Pointer Window

This block turns a fetched 18-bit single-address instruction word into the 13-bit memory address that the instruction operates on. A direct reference needs no memory traffic: the address field is the result. An indirect reference costs one extra read of the cell that the address field names, and the low 13 bits of that cell become the result. Only one level of indirection exists: the upper bits of the fetched pointer cell play no part in the result.

A fixed window of eight pointer cells, word addresses 8 through 15, behaves differently. When an indirect reference lands inside that window, the pointer is incremented by one and written back to the same cell before it is used. A program can therefore walk a table by repeating the same indirect instruction. The block reaches memory through a single word-wide port with a request/ready handshake, and read data arrives one cycle after a read has been accepted. A pulse on `done` presents the result together with the opcode of the instruction. While the block is working it reports `busy` and ignores further start strobes.

Top module: `aix_resolver`

## Requirements
- R1: The instruction word is split as opcode in bits [17:14], indirect flag in bit [13] and address field in bits [12:0]. The opcode appears unchanged on `op_out` when `done` is high.
- R2: With the indirect flag at 0, `done` rises in the first cycle after the clock edge that accepted `start`. `eff_addr` then equals the address field, and no memory request is issued.
- R3: With the indirect flag at 1 and the address field outside the window, exactly one read of the cell at the address field is issued and no write. `eff_addr` equals bits [12:0] of the word that was read, whatever its bits [17:13] hold.
- R4: With the indirect flag at 1 and the address field in 8..15, the cell is read, the value plus one is written back to the same address, and `eff_addr` is bits [12:0] of the incremented value.
- R5: The increment is an 18-bit add modulo 2^18, so 777777 octal becomes 0 in memory and gives an effective address of 0.
- R6: A direct reference to an address in 8..15, or an indirect reference to 7 or 16, leaves memory unchanged.
- R7: `busy` is high from the edge that accepts `start` through the `done` cycle. A `start` seen while `busy` is high is ignored.
- R8: A request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until it is accepted by `mem_ready`. Read data is taken the cycle after acceptance.
- R9: `done` is a single-cycle pulse, and `eff_addr` holds its value until the next `done`.
- R10: Synchronous active-low reset clears `busy`, `done` and `mem_req`.
- R11: With `mem_ready` always high, an indirect reference outside the window completes in 3 cycles and an auto-indexed one in 4, counted the same way as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving `instr` (ignored while busy) |
| instr | input | 18 | Fetched instruction word |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle pulse: result valid |
| eff_addr | output | 13 | Resolved effective address |
| op_out | output | 4 | Opcode of the resolved instruction |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 13 | Memory word address |
| mem_wdata | output | 18 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 18 | Read data, valid the cycle after a read is accepted |

## Verification
The bench builds the block with its default parameters: an 18-bit word, a 13-bit address and an aligned eight-word window based at 8. These defaults select the mask-compare variant of the window decoder and put both window edges (7/8 and 15/16) within one instruction of the stimulus. The 18-bit width makes the all-ones wrap and the carry into bit 13 reachable with small literal patterns. A pseudo-random `mem_ready` mode stretches every handshake so that the hold-until-accepted rule is exercised on both the read and the write-back.

// File: rtl/aix_pkg.sv
// Package: shared state encoding for the effective address resolver.
// Assumes: nothing beyond a synthesizable enum type.
package aix_pkg;

    // Sequencer states of the resolver.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // waiting for a start strobe
        ST_RD     = 3'd1,  // pointer read requested, waiting for ready
        ST_RDWAIT = 3'd2,  // read accepted, data arrives this cycle
        ST_WR     = 3'd3,  // incremented pointer write-back requested
        ST_FIN    = 3'd4   // result valid, done pulse
    } rslv_state_t;

endpackage

// File: rtl/aix_field_split.sv
// Module: aix_field_split
// Splits an instruction word into opcode, indirect flag and address field.
// Assumes: WORD_W == OPC_W + 1 + EA_W, opcode in the top bits, the indirect
// flag directly below it and the address field in the low bits.
module aix_field_split #(
    parameter int WORD_W = 18,
    parameter int EA_W   = 13,
    parameter int OPC_W  = 4
) (
    input  logic [WORD_W-1:0] word,
    output logic [OPC_W-1:0]  opc,
    output logic              ind,
    output logic [EA_W-1:0]   addr
);
    localparam int IND_POS = WORD_W - OPC_W - 1;

    // Purely positional decode of the three fields.
    always_comb begin
        opc  = word[WORD_W-1 -: OPC_W];
        ind  = word[IND_POS];
        addr = word[EA_W-1:0];
    end
endmodule

// File: rtl/aix_window_match.sv
// Module: aix_window_match
// Flags addresses that fall inside the auto-index window [BASE, BASE+SIZE).
// Assumes: SIZE >= 1 and BASE + SIZE <= 2**EA_W. An aligned power-of-two
// window uses a high-bit compare; any other window uses a range compare.
module aix_window_match #(
    parameter int EA_W = 13,
    parameter int BASE = 8,
    parameter int SIZE = 8
) (
    input  logic [EA_W-1:0] addr,
    output logic            hit
);
    localparam bit ALIGNED = ((SIZE & (SIZE - 1)) == 0) && ((BASE % SIZE) == 0);
    localparam int LOG_SZ  = (SIZE > 1) ? $clog2(SIZE) : 0;
    localparam logic [EA_W-1:0] BASE_V = EA_W'(BASE);

    generate
        if (ALIGNED) begin : g_mask
            // Aligned window: only the bits above the window size are compared.
            always_comb hit = (addr[EA_W-1:LOG_SZ] == BASE_V[EA_W-1:LOG_SZ]);
        end else begin : g_range
            // Arbitrary window: two magnitude compares.
            always_comb hit = (32'(addr) >= BASE) && (32'(addr) < (BASE + SIZE));
        end
    endgenerate
endmodule

// File: rtl/aix_incrementer.sv
// Module: aix_incrementer
// Adds one to a pointer word, wrapping modulo 2**WORD_W.
// Assumes: unsigned word, the carry out of the top bit is discarded.
module aix_incrementer #(
    parameter int WORD_W = 18
) (
    input  logic [WORD_W-1:0] val,
    output logic [WORD_W-1:0] sum
);
    // Wrap-around increment; all-ones becomes zero.
    always_comb sum = val + WORD_W'(1);
endmodule

// File: rtl/aix_resolver.sv
// Module: aix_resolver (top)
// Resolves the effective address of one instruction word: direct, single
// level indirect, or indirect through a pre-incremented pointer cell in the
// auto-index window. Talks to memory through a req/ready port with a one
// cycle read latency after acceptance.
// Assumes: memory holds req-qualified outputs stable only while mem_req is
// high; mem_rdata is valid exactly one cycle after a read is accepted.
module aix_resolver #(
    parameter int WORD_W   = 18,
    parameter int EA_W     = 13,
    parameter int OPC_W    = 4,
    parameter int AIX_BASE = 8,
    parameter int AIX_SIZE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    output logic              busy,
    output logic              done,
    output logic [EA_W-1:0]   eff_addr,
    output logic [OPC_W-1:0]  op_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [EA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata
);
    import aix_pkg::*;

    localparam int IND_POS = WORD_W - OPC_W - 1;

    rslv_state_t       state_q;
    logic [EA_W-1:0]   ptr_q;
    logic              win_q;
    logic [WORD_W-1:0] cell_q;
    logic [EA_W-1:0]   ea_q;
    logic [OPC_W-1:0]  opc_q;

    logic [OPC_W-1:0]  f_opc;
    logic              f_ind;
    logic [EA_W-1:0]   f_addr;
    logic              f_win;
    logic [WORD_W-1:0] rd_inc;
    logic              chk_win;

    // Field decode of the incoming instruction.
    aix_field_split #(.WORD_W(WORD_W), .EA_W(EA_W), .OPC_W(OPC_W)) u_split (
        .word (instr),
        .opc  (f_opc),
        .ind  (f_ind),
        .addr (f_addr)
    );

    // Window test on the address field at start time.
    aix_window_match #(.EA_W(EA_W), .BASE(AIX_BASE), .SIZE(AIX_SIZE)) u_win (
        .addr (f_addr),
        .hit  (f_win)
    );

    // Window test on the outgoing memory address, used by the write guard.
    aix_window_match #(.EA_W(EA_W), .BASE(AIX_BASE), .SIZE(AIX_SIZE)) u_win_chk (
        .addr (mem_addr),
        .hit  (chk_win)
    );

    // Pointer increment on the returning read data.
    aix_incrementer #(.WORD_W(WORD_W)) u_inc (
        .val (mem_rdata),
        .sum (rd_inc)
    );

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            win_q   <= 1'b0;
            cell_q  <= '0;
            ea_q    <= '0;
            opc_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        opc_q <= f_opc;
                        ptr_q <= f_addr;
                        win_q <= f_ind & f_win;
                        if (f_ind) begin
                            state_q <= ST_RD;
                        end else begin
                            ea_q    <= f_addr;
                            state_q <= ST_FIN;
                        end
                    end
                end
                ST_RD: begin
                    if (mem_ready) state_q <= ST_RDWAIT;
                end
                ST_RDWAIT: begin
                    if (win_q) begin
                        cell_q  <= rd_inc;
                        state_q <= ST_WR;
                    end else begin
                        ea_q    <= mem_rdata[EA_W-1:0];
                        state_q <= ST_FIN;
                    end
                end
                ST_WR: begin
                    if (mem_ready) begin
                        ea_q    <= cell_q[EA_W-1:0];
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the sequencer state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FIN);
        mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
        mem_we    = (state_q == ST_WR);
        mem_addr  = ptr_q;
        mem_wdata = cell_q;
        eff_addr  = ea_q;
        op_out    = opc_q;
    end

    // Guards.
    AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !instr[IND_POS]) |=> (done && eff_addr == $past(instr[EA_W-1:0]))); // R2
    AST_INDIRECT_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && instr[IND_POS]) |=> (!done && mem_req && !mem_we)); // R3
    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> chk_win); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(eff_addr)); // R9
    AST_BUSY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R7
    AST_OPC_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_out)); // R7
endmodule

// File: tb/aix_resolver_test.sv
`timescale 1ns/1ps
module aix_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [17:0] instr = '0;
    logic        busy, done, mem_req, mem_we;
    logic [12:0] eff_addr, mem_addr;
    logic [3:0]  op_out;
    logic [17:0] mem_wdata;
    logic        mem_ready;
    logic [17:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    aix_resolver uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done), .eff_addr(eff_addr), .op_out(op_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Behavioural memory and independent golden copy.
    logic [17:0] mem  [int];
    logic [17:0] gold [int];
    logic [7:0]  lfsr = 8'hA5;
    bit          stall = 1'b0;
    bit          in_vec = 1'b0;
    bit          exp_wr = 1'b0;
    int          exp_addr = 0;
    logic [17:0] exp_wdata = '0;
    int          wr_cnt = 0;
    int          rd_cnt = 0;

    assign mem_ready = !stall || lfsr[0];

    function automatic logic [17:0] mget(int a);
        return mem.exists(a) ? mem[a] : 18'd0;
    endfunction
    function automatic logic [17:0] gget(int a);
        return gold.exists(a) ? gold[a] : 18'd0;
    endfunction
    function automatic logic [17:0] mk(logic [3:0] opc, logic ind, logic [12:0] a);
        return {opc, ind, a};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, expv);
        end
    endtask

    task automatic poke(int a, logic [17:0] v);
        mem[a]  = v;
        gold[a] = v;
    endtask

    // Memory model with per-clock comparison of every accepted access.
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) begin
                wr_cnt++;
                chk(exp_wr && (int'(mem_addr) == exp_addr), "R4", "write address",
                    mem_addr, exp_addr);
                chk(mem_wdata == exp_wdata, "R5", "write data", mem_wdata, exp_wdata);
                mem[int'(mem_addr)] = mem_wdata;
            end else begin
                rd_cnt++;
                chk(int'(mem_addr) == exp_addr, "R3", "read address", mem_addr, exp_addr);
                mem_rdata <= mget(int'(mem_addr));
            end
        end
        if (rst_n && done && !in_vec)
            chk(1'b0, "R7", "unexpected done", 1, 0);
    end

    task automatic run_vec(logic [17:0] ins, bit intrude, string tag);
        bit          ind = ins[13];
        int          a   = int'(ins[12:0]);
        bit          win = ind && (a >= 8) && (a <= 15);
        logic [17:0] v;
        logic [12:0] exp_ea;
        int          exp_rd, exp_lat, cyc;
        if (!ind) begin
            exp_ea = ins[12:0]; exp_rd = 0; exp_lat = 1;
        end else begin
            v = gget(a);
            if (win) begin
                v = v + 18'd1;
                gold[a] = v;
            end
            exp_ea = v[12:0]; exp_rd = 1; exp_lat = win ? 4 : 3;
        end
        exp_wr = win; exp_addr = a; exp_wdata = v;
        wr_cnt = 0; rd_cnt = 0;
        @(negedge clk);
        in_vec = 1'b1; start = 1'b1; instr = ins;
        @(negedge clk);
        start = 1'b0; cyc = 1;
        chk(busy == 1'b1, "R7", {tag, " busy after start"}, busy, 1);
        if (intrude) begin
            start = 1'b1; instr = mk(4'hE, 1'b0, 13'o7654);
        end
        while (!done && cyc < 400) begin
            @(negedge clk);
            start = 1'b0; cyc++;
        end
        chk(done == 1'b1, "R9", {tag, " done seen"}, done, 1);
        chk(eff_addr == exp_ea, ind ? (win ? "R4" : "R3") : "R2", {tag, " eff_addr"},
            eff_addr, exp_ea);
        chk(op_out == ins[17:14], "R1", {tag, " opcode"}, op_out, ins[17:14]);
        if (!stall)
            chk(cyc == exp_lat, win ? "R11" : (ind ? "R11" : "R2"), {tag, " latency"}, cyc, exp_lat);
        else
            chk(cyc >= exp_lat, "R8", {tag, " stalled latency"}, cyc, exp_lat);
        chk(rd_cnt == exp_rd, "R3", {tag, " read count"}, rd_cnt, exp_rd);
        chk(wr_cnt == (win ? 1 : 0), "R6", {tag, " write count"}, wr_cnt, win ? 1 : 0);
        chk(mget(a) == gget(a), win ? "R5" : "R6", {tag, " cell content"}, mget(a), gget(a));
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R9", {tag, " done pulse width"}, done, 0);
        chk(busy == 1'b0, "R7", {tag, " busy cleared"}, busy, 0);
        chk(eff_addr == exp_ea, "R9", {tag, " eff_addr held"}, eff_addr, exp_ea);
        @(negedge clk);
        chk(busy == 1'b0, "R7", {tag, " intruding start ignored"}, busy, 0);
        in_vec = 1'b0;
        exp_wr = 1'b0;
    endtask

    task automatic suite(string pfx);
        poke(13'o10, 18'o000005);
        poke(13'o12, 18'o000777);
        poke(13'o17, 18'o777777);
        poke(13'o13, 18'o017777);
        poke(13'o7,  18'o004444);
        poke(13'o20, 18'o002222);
        poke(13'o100, 18'o770123);
        poke(13'o200, mk(4'hF, 1'b1, 13'o300));
        run_vec(mk(4'h5, 1'b0, 13'o1234), 1'b0, {pfx, "direct"});           // R2
        run_vec(mk(4'h3, 1'b0, 13'o12),   1'b1, {pfx, "direct-window"});    // R6 R7
        run_vec(mk(4'h4, 1'b1, 13'o100),  1'b0, {pfx, "indirect"});         // R3
        run_vec(mk(4'h9, 1'b1, 13'o200),  1'b0, {pfx, "single-level"});     // R3
        run_vec(mk(4'h1, 1'b1, 13'o10),   1'b0, {pfx, "aix-low"});          // R4
        run_vec(mk(4'h1, 1'b1, 13'o10),   1'b1, {pfx, "aix-again"});        // R4 R7
        run_vec(mk(4'h2, 1'b1, 13'o17),   1'b0, {pfx, "aix-wrap"});         // R5
        run_vec(mk(4'hC, 1'b1, 13'o13),   1'b0, {pfx, "aix-carry"});        // R4
        run_vec(mk(4'h6, 1'b1, 13'o7),    1'b0, {pfx, "below-window"});     // R6
        run_vec(mk(4'h7, 1'b1, 13'o20),   1'b0, {pfx, "above-window"});     // R6
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R10", "reset busy", busy, 0);
        chk(done == 1'b0, "R10", "reset done", done, 0);
        chk(mem_req == 1'b0, "R10", "reset mem_req", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        suite("fast ");
        stall = 1'b1;
        suite("stall ");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule